// File: doc/BRIEF.md
# Eight-Channel Counter Interrupt Aggregator

This block collects single-cycle event pulses from eight counter channels and turns them into one shareable interrupt request. Each channel has an enable bit. When the interrupt function is on and a channel's enable bit is set, that channel's event pulse sets a sticky pending bit. The request line is high while any pending bit is set. Because the line may be shared with other devices, software reads the pending register to find out whether this block raised it. A value of zero means the request came from somewhere else.

Software reaches the block through a byte-wide register port at three offsets:
- The pending register at 0x10 is read-only.
- The command register at 0x11 is write-only.
- The enable register at 0x12 is read/write.

A command byte with bit 4 set turns the interrupt function on and clears every pending bit at once. A command byte with bit 0 set turns the function off, clears the pending bits, and sends a one-cycle reset pulse to the counters.

The enable bits also gate each channel's index-driven preset load. A channel with its interrupts disabled therefore never loads its preset.

A small state machine holds the function state:
- `FN_OFF`: the function is off.
- `FN_ARMED`: the function is on and nothing is pending.
- `FN_PENDING`: the function is on and at least one bit is pending.

Its transitions are:
- `OFF->ARMED`: an enable command arrives.
- `ARMED->PENDING`: an enabled event is latched.
- `PENDING->ARMED`: a clear arrives with no new event in the same cycle.
- `PENDING->PENDING`: a clear arrives together with a new event.
- `ARMED/PENDING->OFF`: a disable command arrives.

Top module: `irq_agg_top`

## Requirements
- R1: After reset the pending register reads 0x00, the enable register reads 0x00, `irq_out` is 0, `ctr_reset` is 0 and the interrupt function is off.
- R2: A write to offset 0x12 stores the byte as the enable register, and a read at 0x12 returns it. Bit N belongs to channel N.
- R3: With the function on, an `evt_pulse[N]` while enable bit N is 1 sets bit N of the pending register (offset 0x10) on the next clock edge. The bit stays set until a clear or a disable command.
- R4: Events are not latched while the function is off. Events on channels whose enable bit is 0 are never latched.
- R5: A command write with bit 4 = 1 and bit 0 = 0 (for example 0x10) turns the function on and clears all pending bits.
- R6: A command write with bit 0 = 1 (for example 0x01 or 0x11) turns the function off and clears all pending bits. In the following cycle it drives `ctr_reset` high for exactly one cycle. Bit 0 takes precedence over bit 4.
- R7: `irq_out` is 1 exactly when the pending register is non-zero, in the same cycle.
- R8: If an enabled event arrives in the same cycle as a clear command, that channel's pending bit is set after the edge.
- R9: `preset_load[N]` equals `index_in[N] AND enable bit N`, combinationally.
- R10: A read at any offset other than 0x10 or 0x12 returns 0x00. A write to offset 0x10 has no effect.
- R11: A command write with neither bit 4 nor bit 0 set has no effect on the pending bits or the function state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 5 | Register offset |
| reg_wr | input | 1 | Write strobe for one cycle |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| evt_pulse | input | 8 | Per-channel event pulses |
| index_in | input | 8 | Per-channel index inputs |
| irq_out | output | 1 | Shared interrupt request, active high |
| preset_load | output | 8 | Per-channel gated preset-load requests |
| ctr_reset | output | 1 | One-cycle counter reset pulse |

## Verification
The bench aims at these cases:
- **Event and clear in the same cycle.** A design that lets the clear win loses an interrupt, and the pending bit reads zero.
- **Events while the function is off, or on a masked channel.** A design that latches them raises a spurious request on the shared line.
- **Command byte 0x11.** Bit 0 must take precedence. A design that decodes bit 4 first would leave the function on and never pulse the counter reset.
- **Command bytes with neither bit set, and writes to the read-only pending offset.** Both are checked to leave the pending state unchanged.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
    typedef enum logic [1:0] {
        FN_OFF     = 2'd0,
        FN_ARMED   = 2'd1,
        FN_PENDING = 2'd2
    } fn_state_e;

    localparam int CMD_BIT_ON  = 4;
    localparam int CMD_BIT_OFF = 0;
endpackage

// File: rtl/irq_agg_regs.sv
module irq_agg_regs #(
    parameter int NCH        = 8,
    parameter int ADDR_W     = 5,
    parameter int OFS_STATUS = 16,
    parameter int OFS_CMD    = 17,
    parameter int OFS_ENABLE = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [NCH-1:0]    reg_wdata,
    input  logic [NCH-1:0]    status,
    input  logic [NCH-1:0]    index_in,
    output logic [NCH-1:0]    enable_q,
    output logic [NCH-1:0]    reg_rdata,
    output logic [NCH-1:0]    preset_load,
    output logic              cmd_on,
    output logic              cmd_off
);
    import irq_agg_pkg::*;

    localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(OFS_STATUS);
    localparam logic [ADDR_W-1:0] A_CMD    = ADDR_W'(OFS_CMD);
    localparam logic [ADDR_W-1:0] A_ENABLE = ADDR_W'(OFS_ENABLE);

    logic wr_cmd;
    assign wr_cmd  = reg_wr && (reg_addr == A_CMD);
    assign cmd_off = wr_cmd && reg_wdata[CMD_BIT_OFF];
    assign cmd_on  = wr_cmd && !reg_wdata[CMD_BIT_OFF] && reg_wdata[CMD_BIT_ON];

    always_ff @(posedge clk) begin
        if (!rst_n)
            enable_q <= '0;
        else if (reg_wr && (reg_addr == A_ENABLE))
            enable_q <= reg_wdata;
    end

    always_comb begin
        unique case (reg_addr)
            A_STATUS: reg_rdata = status;
            A_ENABLE: reg_rdata = enable_q;
            default:  reg_rdata = '0;
        endcase
    end

    assign preset_load = index_in & enable_q;

    AST_ENABLE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == A_ENABLE) |=> (enable_q == $past(reg_wdata))); // R2
endmodule

// File: rtl/irq_agg_fsm.sv
module irq_agg_fsm (
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_on,
    input  logic cmd_off,
    input  logic hit_any,
    output logic func_on,
    output logic irq_out,
    output logic ctr_reset
);
    import irq_agg_pkg::*;

    fn_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= FN_OFF;
            ctr_reset <= 1'b0;
        end else begin
            state_q   <= state_d;
            ctr_reset <= cmd_off;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FN_OFF: begin
                if (cmd_on) state_d = FN_ARMED;
            end
            FN_ARMED: begin
                if (cmd_off)      state_d = FN_OFF;
                else if (hit_any) state_d = FN_PENDING;
            end
            FN_PENDING: begin
                if (cmd_off)     state_d = FN_OFF;
                else if (cmd_on) state_d = hit_any ? FN_PENDING : FN_ARMED;
            end
            default: state_d = FN_OFF;
        endcase
    end

    always_comb begin
        func_on = (state_q != FN_OFF);
        irq_out = (state_q == FN_PENDING);
    end

    AST_DISABLE_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_off |=> (!func_on && !irq_out && ctr_reset)); // R6
    AST_ENABLE_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_on |=> func_on); // R5
    AST_RESET_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (ctr_reset && !$past(cmd_off)) |-> 1'b0); // R6
endmodule

// File: rtl/irq_agg_pending.sv
module irq_agg_pending #(
    parameter int NCH = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           func_on,
    input  logic           cmd_on,
    input  logic           cmd_off,
    input  logic [NCH-1:0] evt_pulse,
    input  logic [NCH-1:0] enable_q,
    output logic [NCH-1:0] status,
    output logic           hit_any
);
    logic [NCH-1:0] hit;

    assign hit_any = |hit;

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        assign hit[i] = func_on && evt_pulse[i] && enable_q[i];

        always_ff @(posedge clk) begin
            if (!rst_n)       status[i] <= 1'b0;
            else if (cmd_off) status[i] <= 1'b0;
            else if (cmd_on)  status[i] <= hit[i];
            else              status[i] <= status[i] | hit[i];
        end

        AST_EVT_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
            (cmd_on && func_on && evt_pulse[i] && enable_q[i]) |=> status[i]); // R8
        AST_MASKED_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
            (!enable_q[i] && !status[i]) |=> !status[i]); // R4
    end

    AST_OFF_NO_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        !func_on |=> (status == '0)); // R4
endmodule

// File: rtl/irq_agg_top.sv
module irq_agg_top #(
    parameter int NCH        = 8,
    parameter int ADDR_W     = 5,
    parameter int OFS_STATUS = 16,
    parameter int OFS_CMD    = 17,
    parameter int OFS_ENABLE = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [NCH-1:0]    reg_wdata,
    output logic [NCH-1:0]    reg_rdata,
    input  logic [NCH-1:0]    evt_pulse,
    input  logic [NCH-1:0]    index_in,
    output logic              irq_out,
    output logic [NCH-1:0]    preset_load,
    output logic              ctr_reset
);
    logic [NCH-1:0] enable_q;
    logic [NCH-1:0] status;
    logic           cmd_on, cmd_off, func_on, hit_any;

    irq_agg_regs #(
        .NCH(NCH), .ADDR_W(ADDR_W),
        .OFS_STATUS(OFS_STATUS), .OFS_CMD(OFS_CMD), .OFS_ENABLE(OFS_ENABLE)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .status(status), .index_in(index_in),
        .enable_q(enable_q), .reg_rdata(reg_rdata), .preset_load(preset_load),
        .cmd_on(cmd_on), .cmd_off(cmd_off)
    );

    irq_agg_pending #(.NCH(NCH)) u_pending (
        .clk(clk), .rst_n(rst_n), .func_on(func_on), .cmd_on(cmd_on),
        .cmd_off(cmd_off), .evt_pulse(evt_pulse), .enable_q(enable_q),
        .status(status), .hit_any(hit_any)
    );

    irq_agg_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .cmd_on(cmd_on), .cmd_off(cmd_off),
        .hit_any(hit_any), .func_on(func_on), .irq_out(irq_out),
        .ctr_reset(ctr_reset)
    );

    AST_IRQ_TRACKS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out == (status != '0)); // R7
    AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_on && ((evt_pulse & enable_q) == '0)) |=> (status == '0)); // R5
endmodule

// File: tb/irq_agg_top_bench.sv
`timescale 1ns/1ps
module irq_agg_top_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] reg_addr = '0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic [7:0] evt_pulse = '0;
    logic [7:0] index_in = '0;
    logic       irq_out;
    logic [7:0] preset_load;
    logic       ctr_reset;
    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    irq_agg_top u_irq_agg_top (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_pulse(evt_pulse),
        .index_in(index_in), .irq_out(irq_out), .preset_load(preset_load),
        .ctr_reset(ctr_reset)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [7:0] d, input logic [7:0] ev = 8'h00);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1; evt_pulse = ev;
        @(negedge clk);
        reg_wr = 1'b0; evt_pulse = '0; reg_addr = 5'h10;
    endtask

    task automatic pulse(input logic [7:0] ev);
        @(negedge clk);
        evt_pulse = ev;
        @(negedge clk);
        evt_pulse = '0;
    endtask

    task automatic rd_chk(input string req, input logic [4:0] a, input logic [7:0] exp);
        reg_addr = a;
        #0.5;
        chk(req, reg_rdata, exp);
    endtask

    task automatic t_reset();
        rd_chk("R1 status", 5'h10, 8'h00);
        rd_chk("R1 enable", 5'h12, 8'h00);
        chk("R1 irq", {7'd0, irq_out}, 8'h00);
        chk("R1 ctr_reset", {7'd0, ctr_reset}, 8'h00);
    endtask

    task automatic t_regs();
        wr(5'h12, 8'hA5);
        rd_chk("R2 enable readback", 5'h12, 8'hA5);
        wr(5'h10, 8'hFF);
        rd_chk("R10 status write ignored", 5'h10, 8'h00);
        rd_chk("R10 unmapped read", 5'h05, 8'h00);
        rd_chk("R10 cmd offset read", 5'h11, 8'h00);
    endtask

    task automatic t_off();
        pulse(8'hFF);
        rd_chk("R4 off no latch", 5'h10, 8'h00);
        chk("R4 off irq", {7'd0, irq_out}, 8'h00);
    endtask

    task automatic t_latch();
        wr(5'h11, 8'h10);
        chk("R5 no irq after enable", {7'd0, irq_out}, 8'h00);
        pulse(8'h0F);
        rd_chk("R3 latch enabled only", 5'h10, 8'h05);
        chk("R7 irq high", {7'd0, irq_out}, 8'h01);
        pulse(8'h00);
        rd_chk("R3 sticky", 5'h10, 8'h05);
        pulse(8'h80);
        rd_chk("R3 accumulate", 5'h10, 8'h85);
    endtask

    task automatic t_clear();
        wr(5'h11, 8'h10);
        rd_chk("R5 cleared", 5'h10, 8'h00);
        chk("R7 irq low", {7'd0, irq_out}, 8'h00);
    endtask

    task automatic t_race();
        wr(5'h11, 8'h10, 8'h03);
        rd_chk("R8 event beats clear", 5'h10, 8'h01);
        chk("R8 irq", {7'd0, irq_out}, 8'h01);
    endtask

    task automatic t_nop_cmd();
        wr(5'h11, 8'h42);
        rd_chk("R11 no-op cmd", 5'h10, 8'h01);
        chk("R11 irq kept", {7'd0, irq_out}, 8'h01);
    endtask

    task automatic t_disable();
        wr(5'h11, 8'h11);
        chk("R6 ctr_reset pulse", {7'd0, ctr_reset}, 8'h01);
        rd_chk("R6 cleared", 5'h10, 8'h00);
        chk("R6 irq low", {7'd0, irq_out}, 8'h00);
        @(negedge clk);
        chk("R6 pulse one cycle", {7'd0, ctr_reset}, 8'h00);
        pulse(8'hFF);
        rd_chk("R6 off after 0x11", 5'h10, 8'h00);
    endtask

    task automatic t_preset();
        @(negedge clk);
        index_in = 8'hFF;
        #0.5;
        chk("R9 preset gate", preset_load, 8'hA5);
        index_in = 8'h3C;
        #0.5;
        chk("R9 preset gate 2", preset_load, 8'h24);
        index_in = 8'h00;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regs();
        t_off();
        t_latch();
        t_clear();
        t_race();
        t_nop_cmd();
        t_disable();
        t_preset();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule